// File: doc/BRIEF.md
# Video DAC Power-Up Register Sequencer

This block brings a colour-palette video DAC from power-up into 24-bit true-colour operation with 2:1 pixel multiplexing. It does this by driving the DAC's parallel register port: a two-bit register select, a read/write line, an 8-bit data bus and a one-cycle write strobe. Nothing has to be written to it from outside. It starts by itself when reset is released and issues a fixed series of writes in order.

The series has four parts. First come five mode-register writes. They pulse the pipeline-reset bit low and then the load-timing synchronisation bit high. Next come four address/data pairs that set the pixel mask and three command registers. Then an address write points the DAC at palette entry zero. Last comes a linear-ramp palette load of three colour writes per entry.

Each write holds its select, data and direction lines for a programmable number of clocks before and after the strobe. When the last blue write completes, a one-cycle done pulse is produced. A start pulse given while the block is idle runs the whole series again. A start pulse given while a series is in progress has no effect.

Top module: `dac_init_seq`

## Requirements
- R1: While rst_n is low, bus_wr and done are 0, bus_rw_n is 1, and bus_sel and bus_data are both zero.
- R2: bus_sel bit 1 is the high select line and bit 0 the low one. 00 selects the address register, 01 the palette, 10 the addressed (indirect) register and 11 the mode register. bus_rw_n is 0 in every strobe cycle.
- R3: The first five writes go to the mode register with data 09h, 08h, 09h, 29h and 09h, in that order. Bit 0 therefore reads 1,0,1,1,1 and bit 5 reads 0,0,0,1,0.
- R4: Writes 6 to 13 are four address/data pairs in this order: 04h then FFh, 05h then 00h, 06h then ECh, 07h then 40h.
- R5: Write 14 loads the address register with 00h. Then, for each n from 0 to ENTRIES-1, three palette writes of data n follow (red, green, blue). A run has exactly 14+3*ENTRIES writes.
- R6: bus_sel, bus_data and bus_rw_n hold their value for at least GAP cycles before each strobe. They do not change in the strobe cycle or in the GAP cycles after it. The strobe lasts exactly one cycle.
- R7: Within a run, consecutive strobes are exactly 2*GAP+2 cycles apart.
- R8: done is high for exactly one cycle, GAP+1 cycles after the final strobe of a run.
- R9: The block starts without any start pulse after reset. The first strobe is visible after GAP+1 rising edges that have rst_n high.
- R10: A start pulse while the block is idle runs the complete series again. Start pulses during a run change neither the write count nor the number of done pulses.
- R11: While the block is idle and start is low, no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the series again; honoured only when idle |
| bus_sel | output | 2 | Register select to the DAC (high line, low line) |
| bus_rw_n | output | 1 | Direction: 0 write, 1 read/idle |
| bus_data | output | 8 | Write data to the DAC |
| bus_wr | output | 1 | One-cycle write strobe |
| done | output | 1 | One-cycle pulse when a series has completed |

## Verification
The bench builds the block with ENTRIES at its full 256 and GAP set to 2. This covers every palette location, including the wrap of the 8-bit ramp at FFh, and a gap long enough for off-by-one setup and hold errors to show up as timing faults. Every strobe across two complete runs is compared with an arithmetically computed write list, and its spacing and setup/hold margins are measured. The bench also places start pulses both during a run and after one, to test that starts are ignored while busy and honoured when idle.

// File: rtl/dac_init_pkg.sv
package dac_init_pkg;

  localparam int DW        = 8;
  localparam int NUM_FIXED = 14;
  localparam int FIX_IW    = 4;

  // select codes: {high line, low line}
  localparam logic [1:0] SEL_ADDR = 2'b00;
  localparam logic [1:0] SEL_PAL  = 2'b01;
  localparam logic [1:0] SEL_IND  = 2'b10;
  localparam logic [1:0] SEL_MODE = 2'b11;

  // mode register: running value and the two bits that get toggled
  localparam logic [DW-1:0] MODE_BASE      = 8'h09;
  localparam int            PIPE_RST_BIT   = 0;
  localparam int            LOAD_SYNC_BIT  = 5;

  typedef struct packed {
    logic [1:0]    sel;
    logic [DW-1:0] data;
  } bus_word_t;

  // mode write k of 0..4: pipeline reset 1-0-1 then load sync 0-1-0
  function automatic logic [DW-1:0] mode_value(input logic [FIX_IW-1:0] k);
    logic [DW-1:0] v;
    v = MODE_BASE;
    if (k == 4'd1) v[PIPE_RST_BIT]  = 1'b0;
    if (k == 4'd3) v[LOAD_SYNC_BIT] = 1'b1;
    return v;
  endfunction

  // the fixed prologue before the palette ramp
  function automatic bus_word_t fixed_word(input logic [FIX_IW-1:0] idx);
    bus_word_t w;
    w.sel  = SEL_ADDR;
    w.data = '0;
    case (idx)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
        w.sel  = SEL_MODE;
        w.data = mode_value(idx);
      end
      4'd5:  w.data = 8'h04;                          // pixel mask address
      4'd6:  begin w.sel = SEL_IND; w.data = 8'hFF; end
      4'd7:  w.data = 8'h05;                          // command 1 address
      4'd8:  begin w.sel = SEL_IND; w.data = 8'h00; end
      4'd9:  w.data = 8'h06;                          // command 2 address
      4'd10: begin w.sel = SEL_IND; w.data = 8'hEC; end
      4'd11: w.data = 8'h07;                          // command 3 address
      4'd12: begin w.sel = SEL_IND; w.data = 8'h40; end
      default: w.data = 8'h00;                        // palette start address
    endcase
    return w;
  endfunction

  function automatic int unsigned total_writes(input int unsigned entries);
    return NUM_FIXED + 3 * entries;
  endfunction

  function automatic int unsigned write_period(input int unsigned gap);
    return 2 * gap + 2;
  endfunction

endpackage

// File: rtl/dac_bus_writer.sv
module dac_bus_writer
  import dac_init_pkg::*;
#(
  parameter int GAP = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go,
  input  bus_word_t word_in,
  output bus_word_t bus_word,
  output logic      bus_rw_n,
  output logic      bus_wr,
  output logic      wr_idle,
  output logic      wr_ack
);

  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GAP - 1);

  typedef enum logic [1:0] {W_IDLE, W_SETUP, W_STROBE, W_HOLD} wstate_t;

  wstate_t       st;
  logic [CW-1:0] cnt;
  logic          cnt_end;

  assign cnt_end = (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cnt      <= '0;
      bus_word <= '0;
      bus_rw_n <= 1'b1;
    end else begin
      case (st)
        W_IDLE: if (go) begin
          bus_word <= word_in;
          bus_rw_n <= 1'b0;
          cnt      <= '0;
          st       <= W_SETUP;
        end
        W_SETUP: if (cnt_end) begin
          cnt <= '0;
          st  <= W_STROBE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        W_STROBE: st <= W_HOLD;
        W_HOLD: if (cnt_end) begin
          cnt      <= '0;
          bus_rw_n <= 1'b1;
          st       <= W_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign bus_wr  = (st == W_STROBE);
  assign wr_idle = (st == W_IDLE);
  assign wr_ack  = (st == W_HOLD) && cnt_end;

endmodule

// File: rtl/dac_step_gen.sv
module dac_step_gen
  import dac_init_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  logic      advance,
  output bus_word_t word,
  output logic      last
);

  localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [EW-1:0]     ENTRY_LAST = EW'(ENTRIES - 1);
  localparam logic [FIX_IW-1:0] FIX_LAST   = FIX_IW'(NUM_FIXED - 1);

  typedef enum logic {PH_FIXED, PH_PAL} phase_t;

  phase_t            phase;
  logic [FIX_IW-1:0] fidx;
  logic [EW-1:0]     entry;
  logic [1:0]        color;   // 0 red, 1 green, 2 blue

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase <= PH_FIXED;
      fidx  <= '0;
      entry <= '0;
      color <= '0;
    end else if (advance) begin
      if (phase == PH_FIXED) begin
        if (fidx == FIX_LAST) phase <= PH_PAL;
        else                  fidx  <= fidx + 1'b1;
      end else if (color == 2'd2) begin
        color <= '0;
        entry <= entry + 1'b1;
      end else begin
        color <= color + 1'b1;
      end
    end
  end

  always_comb begin
    if (phase == PH_FIXED) begin
      word = fixed_word(fidx);
    end else begin
      word.sel  = SEL_PAL;
      word.data = DW'(entry);
    end
  end

  assign last = (phase == PH_PAL) && (color == 2'd2) && (entry == ENTRY_LAST);

endmodule

// File: rtl/dac_run_ctl.sv
module dac_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic wr_ack,
  input  logic step_last,
  output logic go,
  output logic restart,
  output logic advance,
  output logic done,
  output logic running
);

  typedef enum logic [1:0] {RC_IDLE, RC_ISSUE, RC_WAIT} rstate_t;

  rstate_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= RC_ISSUE;   // run begins on its own out of reset
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RC_IDLE:  if (start) st <= RC_ISSUE;
        RC_ISSUE: st <= RC_WAIT;
        RC_WAIT:  if (wr_ack) begin
          if (step_last) begin
            st   <= RC_IDLE;
            done <= 1'b1;
          end else begin
            st <= RC_ISSUE;
          end
        end
        default: st <= RC_IDLE;
      endcase
    end
  end

  assign go      = (st == RC_ISSUE);
  assign restart = (st == RC_IDLE) && start;
  assign advance = (st == RC_WAIT) && wr_ack && !step_last;
  assign running = (st != RC_IDLE);

endmodule

// File: rtl/dac_init_seq.sv
module dac_init_seq
  import dac_init_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int GAP     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [1:0]    bus_sel,
  output logic          bus_rw_n,
  output logic [DW-1:0] bus_data,
  output logic          bus_wr,
  output logic          done
);

  // named internal events, observed by the bound checker
  bus_word_t cur_word;
  bus_word_t out_word;
  logic      step_go;
  logic      step_restart;
  logic      step_advance;
  logic      step_last;
  logic      wr_idle;
  logic      wr_ack;
  logic      running;

  dac_run_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_ack    (wr_ack),
    .step_last (step_last),
    .go        (step_go),
    .restart   (step_restart),
    .advance   (step_advance),
    .done      (done),
    .running   (running)
  );

  dac_step_gen #(.ENTRIES(ENTRIES)) u_steps (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (step_restart),
    .advance (step_advance),
    .word    (cur_word),
    .last    (step_last)
  );

  dac_bus_writer #(.GAP(GAP)) u_writer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (step_go),
    .word_in  (cur_word),
    .bus_word (out_word),
    .bus_rw_n (bus_rw_n),
    .bus_wr   (bus_wr),
    .wr_idle  (wr_idle),
    .wr_ack   (wr_ack)
  );

  assign bus_sel  = out_word.sel;
  assign bus_data = out_word.data;

endmodule

// File: rtl/dac_init_chk.sv
module dac_init_chk
  import dac_init_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int GAP     = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    bus_sel,
  input logic          bus_rw_n,
  input logic [DW-1:0] bus_data,
  input logic          bus_wr,
  input logic          done,
  input logic          step_go,
  input logic          wr_idle,
  input logic          running
);

  localparam int SW = $clog2(2 * GAP + 4) + 1;
  localparam logic [SW-1:0] SAT = '1;
  localparam logic [SW-1:0] PERIOD = SW'(write_period(GAP));

  logic [DW+2:0] lines, prev_lines;
  logic          chg;
  logic [SW-1:0] since_chg, since_wr;
  logic          seen_wr;
  logic [15:0]   wr_in_run;

  assign lines = {bus_sel, bus_data, bus_rw_n};
  assign chg   = (lines != prev_lines);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lines <= {2'b00, {DW{1'b0}}, 1'b1};
      since_chg  <= SAT;
      since_wr   <= SAT;
      seen_wr    <= 1'b0;
      wr_in_run  <= '0;
    end else begin
      prev_lines <= lines;
      since_chg  <= chg ? SW'(1) : ((since_chg == SAT) ? SAT : since_chg + 1'b1);
      since_wr   <= bus_wr ? SW'(1) : ((since_wr == SAT) ? SAT : since_wr + 1'b1);
      if (done) begin
        seen_wr   <= 1'b0;
        wr_in_run <= '0;
      end else if (bus_wr) begin
        seen_wr   <= 1'b1;
        wr_in_run <= wr_in_run + 1'b1;
      end
    end
  end

  // R6
  setup_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (!chg && since_chg >= SW'(GAP)));

  // R6
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (since_wr > SW'(GAP)));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_wr);

  // R2
  strobe_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !bus_rw_n);

  // R7
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && seen_wr) |-> (since_wr == PERIOD));

  // R5
  write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_in_run == 16'(total_writes(ENTRIES))));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && !bus_wr && bus_rw_n));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !bus_wr);

  // R10
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |-> wr_idle);

endmodule

bind dac_init_seq dac_init_chk #(.ENTRIES(ENTRIES), .GAP(GAP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_rw_n (bus_rw_n),
  .bus_data (bus_data),
  .bus_wr   (bus_wr),
  .done     (done),
  .step_go  (step_go),
  .wr_idle  (wr_idle),
  .running  (running)
);

// File: tb/test_dac_init_seq.sv
module test_dac_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int G          = 2;
  localparam int N          = 256;
  localparam int TOTAL      = 14 + 3 * N;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] bus_sel;
  logic       bus_rw_n;
  logic [7:0] bus_data;
  logic       bus_wr;
  logic       done;

  int errors = 0;
  int checks = 0;

  dac_init_seq #(.ENTRIES(N), .GAP(G)) i_dac_init_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_sel  (bus_sel),
    .bus_rw_n (bus_rw_n),
    .bus_data (bus_data),
    .bus_wr   (bus_wr),
    .done     (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected select code of write k (0-based) in a run
  function automatic int exp_sel(input int k);
    if (k < 5)   return 3;
    if (k < 13)  return ((k - 5) % 2 == 0) ? 0 : 2;
    if (k == 13) return 0;
    return 1;
  endfunction

  function automatic int exp_data(input int k);
    case (k)
      0, 2, 4: return 9;
      1:       return 8;
      3:       return 41;
      6:       return 255;
      8:       return 0;
      10:      return 236;
      12:      return 64;
      default: begin
        if (k < 13)  return 4 + (k - 5) / 2;
        if (k == 13) return 0;
        return (k - 14) / 3;
      end
    endcase
  endfunction

  function automatic string req_of(input int k);
    if (k < 5)  return "R3";
    if (k < 13) return "R4";
    return "R5";
  endfunction

  // monitor state
  int   k = 0;
  int   wr_total = 0;
  int   done_cnt = 0;
  int   since_chg = 0;
  int   since_wr = 1000;
  int   edges = 0;
  bit   have_wr = 0;
  bit   first_run = 1;
  bit   prev_done = 0;
  bit   rst_checked = 0;
  logic [10:0] prev_lines = '0;

  always @(negedge clk) begin
    logic [10:0] lines;
    bit          chg;
    lines = {bus_sel, bus_data, bus_rw_n};
    if (!rst_n) begin
      if (!rst_checked) begin
        check(bus_wr == 1'b0,   "R1 bus_wr",   bus_wr, 0);
        check(done == 1'b0,     "R1 done",     done, 0);
        check(bus_rw_n == 1'b1, "R1 bus_rw_n", bus_rw_n, 1);
        check(bus_sel == 2'b00, "R1 bus_sel",  bus_sel, 0);
        check(bus_data == 8'h00,"R1 bus_data", bus_data, 0);
        rst_checked = 1;
      end
      prev_lines = lines;
      since_chg  = 1000;
      since_wr   = 1000;
      edges      = 0;
    end else begin
      chg = (lines != prev_lines);
      if (chg && have_wr)
        check(since_wr > G, "R6 hold after strobe", since_wr, G + 1);
      if (prev_done)
        check(done == 1'b0, "R8 done single cycle", done, 0);
      if (bus_wr) begin
        check(!chg && since_chg >= G, "R6 setup before strobe", since_chg, G);
        check(bus_rw_n == 1'b0, "R2 rw low on write", bus_rw_n, 0);
        check(int'(bus_sel) == exp_sel(k), {req_of(k), " R2 select"}, bus_sel, exp_sel(k));
        check(int'(bus_data) == exp_data(k), {req_of(k), " data"}, bus_data, exp_data(k));
        if (k < 5) begin
          check(bus_data[0] == ((k == 1) ? 1'b0 : 1'b1), "R3 pipeline reset bit", bus_data[0], (k == 1) ? 0 : 1);
          check(bus_data[5] == ((k == 3) ? 1'b1 : 1'b0), "R3 load sync bit", bus_data[5], (k == 3) ? 1 : 0);
        end
        if (k > 0)
          check(since_wr == 2 * G + 2, "R7 strobe spacing", since_wr, 2 * G + 2);
        if (first_run && k == 0)
          check(edges == G + 1, "R9 autostart first strobe", edges, G + 1);
        k++;
        wr_total++;
        have_wr = 1;
      end
      if (done) begin
        check(k == TOTAL, "R5 writes per run", k, TOTAL);
        check(since_wr == G + 1, "R8 done delay", since_wr, G + 1);
        done_cnt++;
        k = 0;
      end
      prev_done  = done;
      since_chg  = chg ? 1 : since_chg + 1;
      since_wr   = bus_wr ? 1 : since_wr + 1;
      edges++;
      prev_lines = lines;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  initial begin
    int w0;
    repeat (5) @(posedge clk);
    @(posedge clk); #1 rst_n = 1'b1;

    wait (done_cnt == 1);
    // R11: idle without start stays quiet
    w0 = wr_total;
    repeat (60) @(posedge clk);
    #1;
    check(wr_total == w0, "R11 no strobes while idle", wr_total - w0, 0);
    check(done_cnt == 1, "R11 no extra done while idle", done_cnt, 1);

    // R10: restart while idle, then ignored starts mid-run
    first_run = 0;
    w0 = wr_total;
    pulse_start();
    repeat (300) @(posedge clk);
    pulse_start();
    repeat (1500) @(posedge clk);
    pulse_start();
    wait (done_cnt == 2);
    #1;
    check(wr_total - w0 == TOTAL, "R10 rerun write count", wr_total - w0, TOTAL);
    w0 = wr_total;
    repeat (40) @(posedge clk);
    #1;
    check(done_cnt == 2, "R10 busy start ignored (done count)", done_cnt, 2);
    check(wr_total == w0, "R10 busy start ignored (no new run)", wr_total - w0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule